// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose and status registers of a processor core that runs in several privilege modes. Software addresses sixteen logical registers with a 4-bit number. The block maps each number to one of its physical registers according to the mode currently on the `mode` input. A change of mode therefore brings in a different stack pointer and link register, and in fast-interrupt mode a different upper half of the register set. No data is copied when the mode changes. The program counter (logical 15) is stored here as an ordinary shared register. How it advances is decided elsewhere.

The core reads two operands and writes one result per cycle. Reads are combinational from the stored state, and a write takes effect at the rising clock edge. A separate port reaches the saved-status word that belongs to the current mode. Another port holds the single current-status word. There is no stream data path, so every pin is a plain control or data pin. There is no back-pressure: a read is always answered in the same cycle, and a write is always accepted. Physical storage totals 37 words: 31 general registers, 5 saved-status words and 1 current-status word.

Top module: `mode_regfile`

## Requirements
- R1: After reset every general register, every saved-status word and the current-status word read as zero.
- R2: `mode` codes are 0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined and 7 system. The unassigned code 6 behaves exactly like user mode.
- R3: Logical r0 to r7 reach the same physical registers in every mode. Logical r8 to r12 reach the same physical registers in every mode except fast interrupt.
- R4: In fast-interrupt mode, logical r8 to r14 reach seven private registers. Writing them leaves the registers that other modes see under those numbers unchanged.
- R5: In interrupt, supervisor, abort and undefined mode, logical r13 and r14 reach a private pair for that mode. Writing them leaves the user r13/r14 and every other mode's pair unchanged.
- R6: System mode reaches exactly the registers user mode reaches, for all sixteen logical numbers.
- R7: Logical r15 is a single register shared by all modes.
- R8: A write on the write port is visible on both read ports from the next cycle. A read of the register being written in the same cycle returns the old value.
- R9: The saved-status port reads and writes the private saved-status word of the current mode. There are five such words: fast interrupt, interrupt, supervisor, abort and undefined.
- R10: In user, system and code-6 mode the saved-status port reads zero, and a write through it changes no saved-status word.
- R11: The current-status word is written by its own enable and reads the new value from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Current processor mode code |
| ra_idx | input | 4 | Logical register number, read port A |
| ra_data | output | DATA_W | Read data, port A |
| rb_idx | input | 4 | Logical register number, read port B |
| rb_data | output | DATA_W | Read data, port B |
| wr_en | input | 1 | Write enable, general registers |
| wr_idx | input | 4 | Logical register number to write |
| wr_data | input | DATA_W | Write data |
| sps_wr_en | input | 1 | Write enable, saved status of the current mode |
| sps_wdata | input | DATA_W | Saved-status write data |
| sps_rdata | output | DATA_W | Saved status of the current mode (zero if the mode has none) |
| cs_wr_en | input | 1 | Write enable, current-status word |
| cs_wdata | input | DATA_W | Current-status write data |
| cs_rdata | output | DATA_W | Current-status word |

## Verification
A write and a read can hit the same physical register in the same cycle. This happens directly, with the same logical number under the same mode. It also happens through aliasing, for example a write to r13 in system mode while port B reads r13 under the same mapping. The bench sets up such collisions on purpose and also lets random traffic produce them. It samples the read ports just before the edge, where the old value is expected, and again in the next cycle, where the new value is expected. A second kind of collision is a saved-status write in a mode without a saved-status word. The bench checks this by reading every exception mode's word afterwards.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [2:0] {
    MD_USR = 3'd0,
    MD_FIQ = 3'd1,
    MD_IRQ = 3'd2,
    MD_SVC = 3'd3,
    MD_ABT = 3'd4,
    MD_UND = 3'd5,
    MD_RSV = 3'd6,
    MD_SYS = 3'd7
  } mode_e;

  localparam int LOG_REGS   = 16;
  localparam int SP_IDX     = 13;
  localparam int LR_IDX     = 14;
  localparam int FIQ_LO     = 8;
  localparam int FIQ_HI     = 14;
  localparam int FIQ_COUNT  = FIQ_HI - FIQ_LO + 1;
  localparam int PAIR_MODES = 4;
  localparam int FIQ_BASE   = LOG_REGS;
  localparam int PAIR_BASE  = FIQ_BASE + FIQ_COUNT;
  localparam int PHYS_REGS  = PAIR_BASE + 2 * PAIR_MODES;
  localparam int SPS_REGS   = PAIR_MODES + 1;

  // slot of the private r13/r14 pair, -1 when the mode has none
  function automatic int pair_slot(mode_e m);
    case (m)
      MD_IRQ:  return 0;
      MD_SVC:  return 1;
      MD_ABT:  return 2;
      MD_UND:  return 3;
      default: return -1;
    endcase
  endfunction

  // slot of the private saved-status word, -1 when the mode has none
  function automatic int sps_slot(mode_e m);
    case (m)
      MD_FIQ:  return 0;
      MD_IRQ:  return 1;
      MD_SVC:  return 2;
      MD_ABT:  return 3;
      MD_UND:  return 4;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/rf_map.sv
module rf_map
  import rf_pkg::*;
#(
  parameter int PIDX_W = 5
) (
  input  logic [2:0]        mode_i,
  input  logic [3:0]        lidx_i,
  output logic [PIDX_W-1:0] pidx_o
);

  mode_e md;
  int    li;
  int    ps;
  int    t;

  always_comb begin
    md = mode_e'(mode_i);
    li = int'(lidx_i);
    ps = pair_slot(md);
    t  = li;
    if (md == MD_FIQ && li >= FIQ_LO && li <= FIQ_HI) begin
      t = FIQ_BASE + li - FIQ_LO;
    end else if (ps >= 0 && (li == SP_IDX || li == LR_IDX)) begin
      t = PAIR_BASE + 2 * ps + (li - SP_IDX);
    end
    pidx_o = PIDX_W'(t);
  end

endmodule

// File: rtl/rf_core.sv
module rf_core #(
  parameter int DATA_W   = 32,
  parameter int NUM_PHYS = 31,
  parameter int PIDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PIDX_W-1:0] wpidx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PIDX_W-1:0] rapidx,
  output logic [DATA_W-1:0] radata,
  input  logic [PIDX_W-1:0] rbpidx,
  output logic [DATA_W-1:0] rbdata
);

  logic [DATA_W-1:0] mem [NUM_PHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_PHYS; k++) mem[k] <= '0;
    end else if (we) begin
      for (int k = 0; k < NUM_PHYS; k++) begin
        if (wpidx == PIDX_W'(k)) mem[k] <= wdata;
      end
    end
  end

  always_comb begin
    radata = '0;
    rbdata = '0;
    for (int k = 0; k < NUM_PHYS; k++) begin
      if (rapidx == PIDX_W'(k)) radata = mem[k];
      if (rbpidx == PIDX_W'(k)) rbdata = mem[k];
    end
  end

endmodule

// File: rtl/rf_status.sv
module rf_status #(
  parameter int DATA_W  = 32,
  parameter int NUM_SPS = 5,
  parameter int SLOT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_vld,
  input  logic [SLOT_W-1:0] slot,
  input  logic              sps_we,
  input  logic [DATA_W-1:0] sps_wdata,
  output logic [DATA_W-1:0] sps_rdata,
  input  logic              cs_we,
  input  logic [DATA_W-1:0] cs_wdata,
  output logic [DATA_W-1:0] cs_rdata
);

  logic [DATA_W-1:0] sps_q [NUM_SPS];
  logic [DATA_W-1:0] cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SPS; k++) sps_q[k] <= '0;
      cs_q <= '0;
    end else begin
      if (sps_we && slot_vld) begin
        for (int k = 0; k < NUM_SPS; k++) begin
          if (slot == SLOT_W'(k)) sps_q[k] <= sps_wdata;
        end
      end
      if (cs_we) cs_q <= cs_wdata;
    end
  end

  always_comb begin
    sps_rdata = '0;
    if (slot_vld) begin
      for (int k = 0; k < NUM_SPS; k++) begin
        if (slot == SLOT_W'(k)) sps_rdata = sps_q[k];
      end
    end
  end

  assign cs_rdata = cs_q;

endmodule

// File: rtl/mode_regfile.sv
module mode_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [3:0]        ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [3:0]        rb_idx,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sps_wr_en,
  input  logic [DATA_W-1:0] sps_wdata,
  output logic [DATA_W-1:0] sps_rdata,
  input  logic              cs_wr_en,
  input  logic [DATA_W-1:0] cs_wdata,
  output logic [DATA_W-1:0] cs_rdata
);

  localparam int PIDX_W = $clog2(PHYS_REGS);
  localparam int SLOT_W = $clog2(SPS_REGS);
  localparam int NPORTS = 3;

  logic [3:0]        map_l [NPORTS];
  logic [PIDX_W-1:0] map_p [NPORTS];
  logic [PIDX_W-1:0] ra_pidx;
  logic [PIDX_W-1:0] rb_pidx;
  logic [PIDX_W-1:0] wr_pidx;

  assign map_l[0] = ra_idx;
  assign map_l[1] = rb_idx;
  assign map_l[2] = wr_idx;

  for (genvar g = 0; g < NPORTS; g++) begin : g_map
    rf_map #(.PIDX_W(PIDX_W)) u_map (
      .mode_i (mode),
      .lidx_i (map_l[g]),
      .pidx_o (map_p[g])
    );
  end

  assign ra_pidx = map_p[0];
  assign rb_pidx = map_p[1];
  assign wr_pidx = map_p[2];

  rf_core #(.DATA_W(DATA_W), .NUM_PHYS(PHYS_REGS), .PIDX_W(PIDX_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_en),
    .wpidx  (wr_pidx),
    .wdata  (wr_data),
    .rapidx (ra_pidx),
    .radata (ra_data),
    .rbpidx (rb_pidx),
    .rbdata (rb_data)
  );

  int                sl;
  logic              slot_vld;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    sl       = sps_slot(mode_e'(mode));
    slot_vld = (sl >= 0);
    slot     = slot_vld ? SLOT_W'(sl) : '0;
  end

  rf_status #(.DATA_W(DATA_W), .NUM_SPS(SPS_REGS), .SLOT_W(SLOT_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_vld  (slot_vld),
    .slot      (slot),
    .sps_we    (sps_wr_en),
    .sps_wdata (sps_wdata),
    .sps_rdata (sps_rdata),
    .cs_we     (cs_wr_en),
    .cs_wdata  (cs_wdata),
    .cs_rdata  (cs_rdata)
  );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int DATA_W = 32,
  parameter int PIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [3:0]        ra_idx,
  input logic [3:0]        wr_idx,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] ra_data,
  input logic [PIDX_W-1:0] ra_pidx,
  input logic [PIDX_W-1:0] wr_pidx,
  input logic [DATA_W-1:0] sps_rdata,
  input logic              cs_wr_en,
  input logic [DATA_W-1:0] cs_wdata,
  input logic [DATA_W-1:0] cs_rdata
);

  AST_LOW_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx < 4'd8) |-> (ra_pidx == PIDX_W'(ra_idx))); // R3

  AST_FIQ_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && ra_idx >= 4'd8 && ra_idx <= 4'd14)
      |-> (ra_pidx >= PIDX_W'(16) && ra_pidx <= PIDX_W'(22))); // R4

  AST_PAIR_PRIVATE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode >= 3'd1 && mode <= 3'd5 && (wr_idx == 4'd13 || wr_idx == 4'd14))
      |-> (wr_pidx >= PIDX_W'(16))); // R5

  AST_SYS_IS_USER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd7) |-> (ra_pidx == PIDX_W'(ra_idx))); // R6

  AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == 4'd15) |-> (ra_pidx == PIDX_W'(15))); // R7

  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_idx) == ra_idx && $past(mode) == mode)
      |-> (ra_data == $past(wr_data))); // R8

  AST_NO_SPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd6 || mode == 3'd7) |-> (sps_rdata == '0)); // R10

  AST_CS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cs_wr_en)) |-> (cs_rdata == $past(cs_wdata))); // R11

endmodule

bind mode_regfile rf_checker #(.DATA_W(DATA_W), .PIDX_W(PIDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .ra_idx    (ra_idx),
  .wr_idx    (wr_idx),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .ra_data   (ra_data),
  .ra_pidx   (ra_pidx),
  .wr_pidx   (wr_pidx),
  .sps_rdata (sps_rdata),
  .cs_wr_en  (cs_wr_en),
  .cs_wdata  (cs_wdata),
  .cs_rdata  (cs_rdata)
);

// File: tb/sim_mode_regfile.sv
`timescale 1ns/1ps
module sim_mode_regfile;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    mode = '0;
  logic [3:0]    ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic [DW-1:0] ra_data, rb_data, wr_data = '0;
  logic          wr_en = 1'b0, sps_wr_en = 1'b0, cs_wr_en = 1'b0;
  logic [DW-1:0] sps_wdata = '0, sps_rdata, cs_wdata = '0, cs_rdata;

  always #4 clk = ~clk;

  mode_regfile #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sps_wr_en(sps_wr_en), .sps_wdata(sps_wdata), .sps_rdata(sps_rdata),
    .cs_wr_en(cs_wr_en), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] m_gpr [31];
  logic [DW-1:0] m_sps [5];
  logic [DW-1:0] m_cs;

  // expected physical slot from R3..R7 (code 6 = user per R2)
  function automatic int exp_phys(int md, int idx);
    if (md == 1 && idx >= 8 && idx <= 14) return 16 + idx - 8;
    if (md >= 2 && md <= 5 && (idx == 13 || idx == 14)) return 23 + 2 * (md - 2) + (idx - 13);
    return idx;
  endfunction

  function automatic int exp_slot(int md);
    if (md >= 1 && md <= 5) return md - 1;
    return -1;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one cycle: drive, check before the edge (old values), update model after
  task automatic step(string req, int md, int ra, int rb, bit we, int wi, logic [DW-1:0] wd,
                      bit swe, logic [DW-1:0] swd, bit cwe, logic [DW-1:0] cwd);
    int sl;
    @(negedge clk);
    mode = 3'(md); ra_idx = 4'(ra); rb_idx = 4'(rb);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    sps_wr_en = swe; sps_wdata = swd; cs_wr_en = cwe; cs_wdata = cwd;
    #1;
    sl = exp_slot(md);
    chk(req, ra_data, m_gpr[exp_phys(md, ra)]);
    chk(req, rb_data, m_gpr[exp_phys(md, rb)]);
    chk(req, sps_rdata, (sl >= 0) ? m_sps[sl] : '0);
    chk(req, cs_rdata, m_cs);
    @(posedge clk);
    if (we) m_gpr[exp_phys(md, wi)] = wd;
    if (swe && sl >= 0) m_sps[sl] = swd;
    if (cwe) m_cs = cwd;
  endtask

  task automatic rd(string req, int md, int ra, int rb);
    step(req, md, ra, rb, 0, 0, '0, 0, '0, 0, '0);
  endtask

  task automatic wr(string req, int md, int wi, logic [DW-1:0] wd);
    step(req, md, wi, wi, 1, wi, wd, 0, '0, 0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5150));
    for (int k = 0; k < 31; k++) m_gpr[k] = '0;
    for (int k = 0; k < 5; k++) m_sps[k] = '0;
    m_cs = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state across all modes and indices
    for (int md = 0; md < 8; md++)
      for (int i = 0; i < 16; i += 2) rd("R1", md, i, i + 1);

    // R5/R6/R2: distinct r13/r14 per mode, then read back everywhere
    for (int md = 0; md < 8; md++) begin
      wr("R5", md, 13, 32'h1300_0000 + md);
      wr("R5", md, 14, 32'h1400_0000 + md);
    end
    for (int md = 0; md < 8; md++) rd("R5", md, 13, 14);
    rd("R6", 7, 13, 14);
    chk("R6", ra_data, 32'h1300_0007);
    rd("R2", 0, 13, 14);
    chk("R2", ra_data, 32'h1300_0007);
    rd("R5", 2, 13, 14);
    chk("R5", ra_data, 32'h1300_0002);

    // R4/R3/R7: fiq upper half private, low half and pc shared
    for (int i = 8; i < 16; i++) wr("R4", 0, i, 32'hA000_0000 + i);
    for (int i = 8; i < 15; i++) wr("R4", 1, i, 32'hF000_0000 + i);
    for (int i = 0; i < 8; i++) wr("R3", 1, i, 32'h0C00_0000 + i);
    wr("R7", 3, 15, 32'h0000_1234);
    for (int md = 0; md < 8; md++)
      for (int i = 0; i < 16; i += 2) rd("R3", md, i, i + 1);
    rd("R4", 3, 8, 12);
    chk("R4", ra_data, 32'hA000_0008);
    rd("R7", 1, 15, 15);
    chk("R7", ra_data, 32'h0000_1234);

    // R8: same-cycle write and read (direct and via system/user alias)
    step("R8", 4, 13, 13, 1, 13, 32'hDEAD_0004, 0, '0, 0, '0);
    rd("R8", 4, 13, 13);
    chk("R8", ra_data, 32'hDEAD_0004);
    step("R8", 7, 5, 5, 1, 5, 32'h5555_0007, 0, '0, 0, '0);
    rd("R8", 0, 5, 5);

    // R9/R10/R11: saved status per mode, ignored where absent
    for (int md = 1; md < 6; md++) step("R9", md, 0, 1, 0, 0, '0, 1, 32'h5A00_0000 + md, 0, '0);
    for (int md = 0; md < 8; md++) rd("R9", md, 0, 1);
    step("R10", 0, 0, 0, 0, 0, '0, 1, 32'hBAD0_0000, 0, '0);
    step("R10", 7, 0, 0, 0, 0, '0, 1, 32'hBAD0_0007, 0, '0);
    step("R10", 6, 0, 0, 0, 0, '0, 1, 32'hBAD0_0006, 0, '0);
    for (int md = 0; md < 8; md++) rd("R10", md, 0, 0);
    rd("R10", 3, 0, 0);
    chk("R10", sps_rdata, 32'h5A00_0003);
    step("R11", 0, 0, 0, 0, 0, '0, 0, '0, 1, 32'hC0DE_0011);
    rd("R11", 5, 0, 0);
    chk("R11", cs_rdata, 32'hC0DE_0011);

    // random traffic mixing all functions
    for (int n = 0; n < 4000; n++) begin
      int md, ra, rb, wi;
      md = int'($urandom_range(0, 7));
      ra = int'($urandom_range(0, 15));
      rb = ((n % 4) == 0) ? -1 : int'($urandom_range(0, 15));
      wi = int'($urandom_range(0, 15));
      if (rb < 0) rb = wi;
      step("R8", md, ra, rb, 1'($urandom_range(0, 1)), wi, $urandom(),
           1'($urandom_range(0, 3) == 0), $urandom(), 1'($urandom_range(0, 7) == 0), $urandom());
    end
    finish_run();
  end

endmodule